// File: doc/BRIEF.md
# Multi-Destination Mapped Interrupt Aggregator

This block collects up to 86 active-high, level-sensitive interrupt lines and fans them out to 9 destination interrupt outputs. Each line latches into a per-source pending flag. A separately held enable flag gates the pending flag, and a routing bit for each destination selects where the gated pending flag is sent. A destination output is high while at least one source routed to it is both pending and enabled. The sources are grouped into three 32-bit banks, and the third bank is only partly populated.

Software reaches the block through a single-cycle, word-addressed 32-bit register port. Enables are never written directly. They change only through a set alias and a clear alias, so two agents can change different bits without a read-modify-write race. Pending flags are acknowledged by writing ones. Each destination has a read-only identity word per bank that shows which sources are currently driving it. A handler reads that word and then acknowledges exactly those bits.

Top module: `irq_route_hub`

## Requirements
- R1: After a synchronous active-high reset, every pending, enable and routing bit is 0, all `irq_out` bits are 0 and `rsp_rdata` is 0.
- R2: A write to a pending word (word addresses 12, 13, 14 for banks 0, 1, 2) clears each pending bit whose write-data bit is 1. Bits written 0 keep their value. Pending words read back their current value.
- R3: A source line sampled high at a clock edge sets its pending bit from that edge on. If the line is high in the same cycle as an acknowledge of that bit, the bit stays 1.
- R4: The enable words (addresses 18, 19, 20) are readable. A write to the set alias (addresses 24, 25, 26) sets each enable bit whose data bit is 1 and leaves all other enable bits unchanged.
- R5: A write to the clear alias (addresses 21, 22, 23) clears each enable bit whose data bit is 1 and leaves the others unchanged, so all ones clears a whole bank in one access. Enable bits change through no other path: a write to an enable word address is ignored.
- R6: Routing word for bank b and destination n sits at address 30 + 9*b + n, is read/write, and a 1 in bit i routes source 32*b + i to destination n.
- R7: Identity word for bank b and destination n sits at address 57 + 9*b + n and reads pending AND enable AND routing for that bank and destination. Writes to it are ignored.
- R8: `irq_out[n]` is the OR of all identity bits of destination n over the three banks. It follows the register state of the same cycle, with no extra register.
- R9: Bits for the absent sources 86 to 95 (bank 2, bits 22 to 31) read 0 and ignore writes. Reads of the set and clear aliases and of any unlisted address return 0.
- R10: A read request captures the addressed word at the clock edge where it is presented. `rsp_rdata` shows it after that edge and holds it until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NUM_SRC | Level-sensitive source lines, active high |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_DST | Destination interrupt outputs |

## Verification
The assertions assume that the source lines are synchronous to `clk` and that only one register access arrives per cycle. Because of that, a set-alias write and a clear-alias write can never land on the same edge. The bench drives the lines and the request fields on the falling edge only, and it issues accesses one after another. Random source patterns are kept sparse and are dropped after one cycle, so that acknowledges can actually clear bits. The random addresses cover every decoded word and also some unlisted ones.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int WORD_W = 32;

  // Word addresses of the register groups; software decodes these
  localparam int PEND_BASE    = 12;
  localparam int ENA_BASE     = 18;
  localparam int ENA_CLR_BASE = 21;
  localparam int ENA_SET_BASE = 24;
  localparam int ROUTE_BASE   = 30;

  function automatic int banks_for(input int n_src);
    return (n_src + WORD_W - 1) / WORD_W;
  endfunction

  // Bits of a bank that correspond to a real source
  function automatic logic [WORD_W-1:0] live_bits(input int n_src, input int bank);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = ((bank * WORD_W + i) < n_src);
    return m;
  endfunction

  // Acknowledge first, then the line sets: a held line wins
  function automatic logic [WORD_W-1:0] pend_next(input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] ack,
                                                  input logic [WORD_W-1:0] lines);
    return (cur & ~ack) | lines;
  endfunction

  function automatic logic [WORD_W-1:0] ena_next(input logic [WORD_W-1:0] cur,
                                                 input logic [WORD_W-1:0] set_m,
                                                 input logic [WORD_W-1:0] clr_m);
    return (cur & ~clr_m) | set_m;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 86,
  parameter int BANK    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] lines,
  input  logic              ack_we,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] pend_q,
  output logic [WORD_W-1:0] ena_q
);
  localparam logic [WORD_W-1:0] LIVE = live_bits(NUM_SRC, BANK);

  logic [WORD_W-1:0] ack_bits, set_bits, clr_bits;
  assign ack_bits = ack_we ? wdata : '0;
  assign set_bits = set_we ? wdata : '0;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      ena_q  <= '0;
    end else begin
      pend_q <= pend_next(pend_q, ack_bits, lines) & LIVE;
      ena_q  <= ena_next(ena_q, set_bits, clr_bits) & LIVE;
    end
  end
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 86,
  parameter int NUM_DST = 9,
  parameter int BANK    = 0
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_DST-1:0]              route_we,
  input  logic [WORD_W-1:0]               wdata,
  output logic [NUM_DST-1:0][WORD_W-1:0]  route_q
);
  localparam logic [WORD_W-1:0] LIVE = live_bits(NUM_SRC, BANK);

  for (genvar n = 0; n < NUM_DST; n++) begin : g_dst
    always_ff @(posedge clk) begin
      if (rst)              route_q[n] <= '0;
      else if (route_we[n]) route_q[n] <= wdata & LIVE;
    end
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_route_pkg::*;
#(
  parameter int NUM_BANK = 3,
  parameter int NUM_DST  = 9,
  parameter int ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0]                             addr,
  input  logic [NUM_BANK-1:0][WORD_W-1:0]               pend,
  input  logic [NUM_BANK-1:0][WORD_W-1:0]               ena,
  input  logic [NUM_BANK-1:0][NUM_DST-1:0][WORD_W-1:0]  route,
  input  logic [NUM_BANK-1:0][NUM_DST-1:0][WORD_W-1:0]  ident,
  output logic [WORD_W-1:0]                             rd_word
);
  localparam int IDENT_BASE = ROUTE_BASE + NUM_BANK * NUM_DST;

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANK; b++) begin
      if (int'(addr) == PEND_BASE + b) rd_word = pend[b];
      if (int'(addr) == ENA_BASE + b)  rd_word = ena[b];
      for (int n = 0; n < NUM_DST; n++) begin
        if (int'(addr) == ROUTE_BASE + b * NUM_DST + n) rd_word = route[b][n];
        if (int'(addr) == IDENT_BASE + b * NUM_DST + n) rd_word = ident[b][n];
      end
    end
  end
endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 86,
  parameter int NUM_DST = 9,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic [31:0]        rsp_rdata,
  output logic [NUM_DST-1:0] irq_out
);
  localparam int NUM_BANK = banks_for(NUM_SRC);
  localparam int TOT_W    = NUM_BANK * WORD_W;

  logic wr_go, rd_go;
  assign wr_go = req_valid & req_write;
  assign rd_go = req_valid & ~req_write;

  logic [NUM_BANK-1:0][WORD_W-1:0]              src_b, pend_b, ena_b, ack_b;
  logic [NUM_BANK-1:0][NUM_DST-1:0][WORD_W-1:0] route_b, ident_b;
  logic [NUM_BANK-1:0]                          ena_wr_b;

  // Named internal events for the checker
  logic [TOT_W-1:0]              src_pad, pend_all, ena_all, ack_all;
  logic                          ena_wr_any;
  logic [NUM_DST-1:0][TOT_W-1:0] ident_all;

  assign src_b      = TOT_W'(src_in);
  assign src_pad    = src_b;
  assign pend_all   = pend_b;
  assign ena_all    = ena_b;
  assign ack_all    = ack_b;
  assign ena_wr_any = |ena_wr_b;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic ack_we, set_we, clr_we;
    logic [NUM_DST-1:0] route_we;

    assign ack_we = wr_go && (int'(req_addr) == PEND_BASE + b);
    assign set_we = wr_go && (int'(req_addr) == ENA_SET_BASE + b);
    assign clr_we = wr_go && (int'(req_addr) == ENA_CLR_BASE + b);
    assign ack_b[b]    = ack_we ? req_wdata : '0;
    assign ena_wr_b[b] = set_we | clr_we;

    for (genvar n = 0; n < NUM_DST; n++) begin : g_we
      assign route_we[n] = wr_go && (int'(req_addr) == ROUTE_BASE + b * NUM_DST + n);
      assign ident_b[b][n] = pend_b[b] & ena_b[b] & route_b[b][n];
    end

    irq_src_bank #(.NUM_SRC(NUM_SRC), .BANK(b)) src_i (
      .clk(clk), .rst(rst), .lines(src_b[b]),
      .ack_we(ack_we), .set_we(set_we), .clr_we(clr_we), .wdata(req_wdata),
      .pend_q(pend_b[b]), .ena_q(ena_b[b])
    );

    irq_route_bank #(.NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .BANK(b)) route_i (
      .clk(clk), .rst(rst), .route_we(route_we), .wdata(req_wdata),
      .route_q(route_b[b])
    );
  end

  always_comb begin
    for (int n = 0; n < NUM_DST; n++)
      for (int b = 0; b < NUM_BANK; b++)
        ident_all[n][b*WORD_W +: WORD_W] = ident_b[b][n];
  end

  for (genvar n = 0; n < NUM_DST; n++) begin : g_out
    assign irq_out[n] = |ident_all[n];
  end

  logic [WORD_W-1:0] rd_word;
  irq_read_mux #(.NUM_BANK(NUM_BANK), .NUM_DST(NUM_DST), .ADDR_W(ADDR_W)) mux_i (
    .addr(req_addr), .pend(pend_b), .ena(ena_b), .route(route_b),
    .ident(ident_b), .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst)        rsp_rdata <= '0;
    else if (rd_go) rsp_rdata <= rd_word;
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_SRC  = 86,
  parameter int NUM_DST  = 9,
  parameter int NUM_BANK = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_BANK*32-1:0]    src_pad,
  input logic [NUM_BANK*32-1:0]    pend_all,
  input logic [NUM_BANK*32-1:0]    ena_all,
  input logic [NUM_BANK*32-1:0]    ack_all,
  input logic                      ena_wr_any,
  input logic [NUM_DST-1:0]        irq_out
);
  localparam int TOT_W = NUM_BANK * 32;
  localparam logic [TOT_W-1:0] LIVE = (TOT_W'(1) << NUM_SRC) - TOT_W'(1);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_line_sets_R3: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((pend_all & $past(src_pad)) == $past(src_pad)));

  assert_ack_clears_R2: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((pend_all & $past(ack_all & ~src_pad)) == '0));

  assert_ena_only_alias_R5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(ena_wr_any)) |-> (ena_all == $past(ena_all)));

  assert_irq_needs_live_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> ((pend_all & ena_all) != '0));

  assert_absent_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ((pend_all | ena_all) & ~LIVE) == '0);
endmodule

bind irq_route_hub irq_route_chk #(
  .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .NUM_BANK(NUM_BANK)
) chk_i (
  .clk(clk), .rst(rst), .src_pad(src_pad), .pend_all(pend_all),
  .ena_all(ena_all), .ack_all(ack_all), .ena_wr_any(ena_wr_any),
  .irq_out(irq_out)
);

// File: tb/irq_route_hub_tb.sv
`timescale 1ns/1ps
module irq_route_hub_tb_top;
  localparam int NS = 86;
  localparam int ND = 9;
  localparam logic [95:0] LIVE = (96'd1 << NS) - 96'd1;

  logic clk = 1'b0;
  logic rst;
  logic [NS-1:0] src_in;
  logic req_valid, req_write;
  logic [7:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic [ND-1:0] irq_out;

  always #2.5 clk = ~clk;

  irq_route_hub dut_i (
    .clk(clk), .rst(rst), .src_in(src_in), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [95:0] m_pend, m_ena;
  logic [95:0] m_route [ND];
  logic [31:0] last_rd;

  // Reference model written from the requirements
  always @(posedge clk) begin
    int a;
    logic [95:0] w;
    if (rst) begin
      m_pend = '0; m_ena = '0;
      for (int n = 0; n < ND; n++) m_route[n] = '0;
    end else begin
      a = int'(req_addr);
      if (req_valid && req_write) begin
        if (a >= 12 && a <= 14) begin
          w = 96'(req_wdata) << (32 * (a - 12));
          m_pend = m_pend & ~w;
        end
        if (a >= 24 && a <= 26) m_ena = (m_ena | (96'(req_wdata) << (32 * (a - 24)))) & LIVE;
        if (a >= 21 && a <= 23) m_ena = m_ena & ~(96'(req_wdata) << (32 * (a - 21)));
        if (a >= 30 && a <= 56) begin
          w = 96'hFFFFFFFF << (32 * ((a - 30) / 9));
          m_route[(a - 30) % 9] = ((m_route[(a - 30) % 9] & ~w)
                                  | (96'(req_wdata) << (32 * ((a - 30) / 9)))) & LIVE;
        end
      end
      m_pend = (m_pend | 96'(src_in)) & LIVE;
    end
  end

  function automatic logic [31:0] exp_read(input int a);
    logic [95:0] v;
    v = '0;
    if (a >= 12 && a <= 14) v = m_pend >> (32 * (a - 12));
    if (a >= 18 && a <= 20) v = m_ena >> (32 * (a - 18));
    if (a >= 30 && a <= 56) v = m_route[(a - 30) % 9] >> (32 * ((a - 30) / 9));
    if (a >= 57 && a <= 83) v = (m_pend & m_ena & m_route[(a - 57) % 9]) >> (32 * ((a - 57) / 9));
    return v[31:0];
  endfunction

  function automatic logic [ND-1:0] exp_irq();
    logic [ND-1:0] r;
    for (int n = 0; n < ND; n++) r[n] = |(m_pend & m_ena & m_route[n]);
    return r;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input string tag);
    chk(32'(irq_out), 32'(exp_irq()), tag);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    e = exp_read(a);
    req_valid = 1; req_write = 0; req_addr = 8'(a);
    @(negedge clk);
    req_valid = 0;
    last_rd = e;
    chk(rsp_rdata, e, tag);
  endtask

  task automatic pulse(input logic [NS-1:0] s);
    @(negedge clk); src_in = s;
    @(negedge clk); src_in = '0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; src_in = '0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(32'(irq_out), 32'd0, "R1 irq_out after reset");
    chk(rsp_rdata, 32'd0, "R1 rdata after reset");
    rd(12, "R1 pending bank0 reset");
    rd(20, "R1 enable bank2 reset");
    rd(44, "R1 route reset");

    // R3: line sets pending; R8: not enabled, no output
    pulse(NS'(1) << 5);
    rd(12, "R3 pending set by line");
    chk(rsp_rdata, 32'h20, "R3 pending bit5 literal");
    chk_irq("R8 no output without enable");

    // R4 set alias, R6 route, R8 output, R7 identity
    wr(24, 32'h20);
    rd(18, "R4 enable via set alias");
    wr(33, 32'h20);
    rd(33, "R6 route readback");
    @(negedge clk);
    chk_irq("R8 output from routed source");
    chk(32'(irq_out), 32'h8, "R8 dst3 literal");
    rd(60, "R7 identity dst3 bank0");
    wr(60, 32'hFFFFFFFF);
    rd(60, "R7 identity ignores writes");

    // R5: direct enable write ignored
    wr(18, 32'h0);
    rd(18, "R5 direct enable write ignored");

    // R3: set wins over acknowledge
    @(negedge clk); src_in = NS'(1) << 5;
    req_valid = 1; req_write = 1; req_addr = 8'd12; req_wdata = 32'h20;
    @(negedge clk); req_valid = 0; req_write = 0; src_in = '0;
    rd(12, "R3 line held across ack keeps bit");
    wr(12, 32'h0);
    rd(12, "R2 zero ack has no effect");
    wr(12, 32'h20);
    rd(12, "R2 ack clears");
    chk_irq("R8 output drops after ack");

    // R9 absent bits and unlisted addresses
    wr(56, 32'hFFFFFFFF);
    rd(56, "R9 bank2 route upper bits");
    chk(rsp_rdata, 32'h003FFFFF, "R9 bank2 route literal");
    wr(26, 32'hFFFFFFFF);
    rd(20, "R9 bank2 enable upper bits");
    rd(240, "R9 unlisted address");
    rd(24, "R9 set alias reads zero");
    rd(21, "R9 clear alias reads zero");

    // R10 hold
    rd(56, "R10 read capture");
    repeat (3) @(negedge clk);
    chk(rsp_rdata, last_rd, "R10 rdata held while idle");

    // R5 all ones clears a bank, others untouched
    wr(24, 32'hFFFFFFFF); wr(25, 32'hFFFFFFFF);
    wr(21, 32'hFFFFFFFF);
    rd(18, "R5 all ones clear bank0");
    rd(19, "R5 bank1 untouched");
    wr(22, 32'h0000FF00);
    rd(19, "R5 partial clear");

    // Constrained random
    for (int it = 0; it < 600; it++) begin
      int op;
      int a;
      logic [31:0] d;
      op = $urandom_range(0, 3);
      case (op)
        0: pulse(NS'({$urandom(), $urandom(), $urandom()}) & NS'({$urandom(), $urandom(), $urandom()})
                 & NS'({$urandom(), $urandom(), $urandom()}));
        1: begin
          a = $urandom_range(10, 90);
          d = ($urandom_range(0, 3) == 0) ? 32'hFFFFFFFF : $urandom();
          wr(a, d);
        end
        2: begin
          a = $urandom_range(10, 90);
          rd(a, "R2 R4 R6 R7 random read");
        end
        default: begin
          @(negedge clk);
          chk_irq("R8 random output");
        end
      endcase
    end

    done = 1;
    summary();
  end
endmodule